// File: doc/BRIEF.md
# Direct-mapped write-through cache with no allocation on store misses

This block sits between a processor request port and a memory port whose latency varies. It holds a small direct-mapped array of one-word lines. A load that finds its line present is answered from the array without touching memory. A load that misses issues one memory read, places the returned word in its line and passes the word back. Every store is forwarded to memory. A store whose address is resident also refreshes the cached word. A store that misses changes nothing in the array.

Each line keeps only a valid flag and a tag. Because memory always holds the current value, no line is ever dirty and an eviction never needs a write-back. The processor side uses a valid/ready handshake and accepts one request at a time. Every response carries a latency class flag: it is low when only the array was used and high when memory took part.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address is answered with the class flag high; while idle after reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A load whose line is valid with a matching tag returns the cached word with `rsp_mem` = 0, raises `rsp_valid` exactly 2 cycles after the accepting edge, and issues no memory read.
- R3: A load that misses issues exactly one memory read (`mem_req_we` = 0) to the load address, returns the word memory delivers with `rsp_mem` = 1, and fills the line so the next load to that address hits.
- R4: A store whose line is resident issues one memory write of the store address and data, and updates the cached word so a following load hits and returns the stored data.
- R5: A store that misses issues one memory write of the store address and data and leaves every line unchanged: a load to the stored address still misses, and whatever line occupied that index still hits.
- R6: For a store, `mem_req_valid` with `mem_req_we` = 1 is raised in the first cycle after the accepting edge, which is the same cycle in which the tag is compared. Every store response has `rsp_mem` = 1.
- R7: Only one request is outstanding. `req_ready` is 0 from the cycle after an accepting edge until the cycle after `rsp_valid`. No memory request is raised while `req_ready` is 1.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request (valid, write flag, address, data) stays unchanged.
- R9: The line index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. A load miss to an address with the same index but a different tag replaces the resident line, so the earlier address then misses.
- R10: `rsp_valid` is a single-cycle pulse per request, and memory answers each memory request (read or write) with one `mem_rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Load data (meaningful for loads) |
| rsp_mem | output | 1 | Latency class: 0 = array only, 1 = memory involved |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion pulse |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
The hardest case to reach from the ports is a store miss landing on an index that is already occupied by another tag. The cache must leave that line alone, and the effect shows up only on later loads. The stimulus fills a line with a load, stores to an address with the same index and a different tag, and then loads both addresses: the first must still hit and the stored one must miss and return the new value. A stretch of pseudo-random loads and stores over three tags and four indices follows, with stalls of different lengths on the memory side. It is checked against a bench model of valid flags, tags and memory contents.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_LOOK  = 3'd1,
    ST_RD_MREQ  = 3'd2,
    ST_RD_MWAIT = 3'd3,
    ST_WR_MREQ  = 3'd4,
    ST_WR_MWAIT = 3'd5,
    ST_RESP     = 3'd6
  } wtc_state_e;

endpackage

// File: rtl/wtc_rst_sync.sv
module wtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/wtc_tag_array.sv
module wtc_tag_array #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] line_idx,
  input  logic [TAG_W-1:0] line_tag,
  output logic             lkp_hit
);

  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_vec;
  logic [TAG_W-1:0] tag_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             sel;
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    assign sel = fill_en && (line_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) t_q <= line_tag;
    end

    assign valid_vec[g] = v_q;
    assign tag_vec[g]   = t_q;
  end

  assign lkp_hit = valid_vec[line_idx] && (tag_vec[line_idx] == line_tag);

endmodule

// File: rtl/wtc_data_array.sv
module wtc_data_array #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_vec [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_word
    logic [DATA_W-1:0] w_q;

    always_ff @(posedge clk) begin
      if (wr_en && (line_idx == IDX_W'(g))) w_q <= wr_data;
    end

    assign word_vec[g] = w_q;
  end

  assign rd_data = word_vec[line_idx];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_mem,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [IDX_W-1:0]  line_idx,
  output logic [TAG_W-1:0]  line_tag,
  input  logic              lkp_hit,
  input  logic [DATA_W-1:0] lkp_data,
  output logic              fill_en,
  output logic              word_wr_en,
  output logic [DATA_W-1:0] word_wr_data
);

  wtc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              mem_q, mem_d;
  logic              cap_en, rdata_en, class_en;

  // next-state and datapath control
  always_comb begin
    state_d      = state_q;
    cap_en       = 1'b0;
    rdata_en     = 1'b0;
    rdata_d      = mem_rsp_rdata;
    class_en     = 1'b0;
    mem_d        = 1'b1;
    fill_en      = 1'b0;
    word_wr_en   = 1'b0;
    word_wr_data = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = req_we ? ST_WR_MREQ : ST_RD_LOOK;
        end
      end
      ST_RD_LOOK: begin
        if (lkp_hit) begin
          rdata_en = 1'b1;
          rdata_d  = lkp_data;
          class_en = 1'b1;
          mem_d    = 1'b0;
          state_d  = ST_RESP;
        end else begin
          state_d = ST_RD_MREQ;
        end
      end
      ST_RD_MREQ: begin
        if (mem_req_ready) state_d = ST_RD_MWAIT;
      end
      ST_RD_MWAIT: begin
        if (mem_rsp_valid) begin
          fill_en      = 1'b1;
          word_wr_en   = 1'b1;
          word_wr_data = mem_rsp_rdata;
          rdata_en     = 1'b1;
          class_en     = 1'b1;
          state_d      = ST_RESP;
        end
      end
      ST_WR_MREQ: begin
        // tag compare runs alongside the outgoing memory write
        if (mem_req_ready) begin
          word_wr_en = lkp_hit;
          state_d    = ST_WR_MWAIT;
        end
      end
      ST_WR_MWAIT: begin
        if (mem_rsp_valid) begin
          class_en = 1'b1;
          state_d  = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mem_q <= 1'b0;
    else if (class_en) mem_q <= mem_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign rsp_mem       = mem_q;
  assign mem_req_valid = (state_q == ST_RD_MREQ) || (state_q == ST_WR_MREQ);
  assign mem_req_we    = we_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign line_idx      = addr_q[IDX_W-1:0];
  assign line_tag      = addr_q[ADDR_W-1:IDX_W];

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_mem,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic              rst_core_n;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  line_tag;
  logic              lkp_hit;
  logic [DATA_W-1:0] lkp_data;
  logic              fill_en;
  logic              word_wr_en;
  logic [DATA_W-1:0] word_wr_data;

  wtc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  wtc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fill_en  (fill_en),
    .line_idx (line_idx),
    .line_tag (line_tag),
    .lkp_hit  (lkp_hit)
  );

  wtc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .wr_en    (word_wr_en),
    .line_idx (line_idx),
    .wr_data  (word_wr_data),
    .rd_data  (lkp_data)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_mem       (rsp_mem),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .line_idx      (line_idx),
    .line_tag      (line_tag),
    .lkp_hit       (lkp_hit),
    .lkp_data      (lkp_data),
    .fill_en       (fill_en),
    .word_wr_en    (word_wr_en),
    .word_wr_data  (word_wr_data)
  );

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic              rsp_valid,
  input logic              rsp_mem,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata
);

  logic pend_we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_we_q <= 1'b0;
    else if (req_valid && req_ready) pend_we_q <= req_we;
  end

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  p_idle_no_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  p_store_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> (mem_req_valid && mem_req_we));

  p_store_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_we_q) |-> rsp_mem);

  p_read_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_we == pend_we_q));

  p_hit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mem) |-> $past(req_valid && req_ready, 2));

endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_we        (req_we),
  .rsp_valid     (rsp_valid),
  .rsp_mem       (rsp_mem),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/wt_cache_tb.sv
module wt_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int LN = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_mem;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_mem(rsp_mem),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] mem_default(input logic [AW-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  // memory model with varying stalls
  logic [DW-1:0] mem_store [logic [AW-1:0]];
  int            mem_rd_cnt = 0;
  int            mem_wr_cnt = 0;
  int            mem_first_cyc = 0;
  logic [AW-1:0] mem_last_addr;
  logic [DW-1:0] mem_last_data;
  int            dly_ctr = 0;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        int            d1;
        int            d2;
        logic [AW-1:0] a0;
        logic          w0;
        d1 = dly_ctr % 3;
        d2 = (dly_ctr / 3) % 4;
        dly_ctr++;
        a0 = mem_req_addr;
        mem_first_cyc = cyc;
        repeat (d1) @(negedge clk);
        chk(mem_req_valid && (mem_req_addr == a0), "R8 request held", {16'h0, mem_req_addr}, {16'h0, a0});
        w0 = mem_req_we;
        mem_last_addr = mem_req_addr;
        mem_last_data = mem_req_wdata;
        if (w0) begin
          mem_store[mem_req_addr] = mem_req_wdata;
          mem_wr_cnt++;
        end else begin
          mem_rd_cnt++;
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (d2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        if (w0) mem_rsp_rdata = '0;
        else    mem_rsp_rdata = mem_store.exists(a0) ? mem_store[a0] : mem_default(a0);
      end
    end
  end

  // scoreboard
  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_hit;
    logic          exp_mem;
    string         rq;
    int            cyc;
    int            nrd;
    int            nwr;
  } item_t;

  item_t         sb[$];
  logic [DW-1:0] ref_mem [logic [AW-1:0]];
  logic          mdl_v [LN];
  logic [AW-IW-1:0] mdl_t [LN];

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : mem_default(a);
  endfunction

  task automatic do_req(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string rq);
    item_t         it;
    logic [IW-1:0] ix;
    ix = a[IW-1:0];
    it.we      = we;
    it.addr    = a;
    it.data    = we ? d : ref_rd(a);
    it.rq      = rq;
    it.exp_hit = mdl_v[ix] && (mdl_t[ix] == a[AW-1:IW]);
    it.exp_mem = we ? 1'b1 : !it.exp_hit;
    if (we) ref_mem[a] = d;
    else begin
      mdl_v[ix] = 1'b1;
      mdl_t[ix] = a[AW-1:IW];
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    it.cyc = cyc; it.nrd = mem_rd_cnt; it.nwr = mem_wr_cnt;
    sb.push_back(it);
    @(negedge clk);
    chk(!req_ready, "R7 busy after accept", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b0;
    while (sb.size() != 0 && !done) @(negedge clk);
  endtask

  // monitor
  bit prev_rsp = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (prev_rsp) chk(!rsp_valid, "R10 response pulse", {31'h0, rsp_valid}, 32'h0);
      prev_rsp = rsp_valid;
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 unexpected response", 32'h1, 32'h0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(rsp_mem == it.exp_mem, {it.rq, " latency class"}, {31'h0, rsp_mem}, {31'h0, it.exp_mem});
          if (!it.we) begin
            chk(rsp_rdata == it.data, {it.rq, " load data"}, rsp_rdata, it.data);
            if (it.exp_hit) begin
              chk(cyc - it.cyc == 2, "R2 hit latency", cyc - it.cyc, 32'd2);
              chk(mem_rd_cnt == it.nrd, "R2 no memory read on hit", mem_rd_cnt, it.nrd);
            end else begin
              chk(mem_rd_cnt == it.nrd + 1, "R3 one memory read", mem_rd_cnt, it.nrd + 1);
              chk(mem_last_addr == it.addr, "R3 read address", {16'h0, mem_last_addr}, {16'h0, it.addr});
            end
          end else begin
            chk(mem_wr_cnt == it.nwr + 1, {it.rq, " one memory write"}, mem_wr_cnt, it.nwr + 1);
            chk(mem_last_addr == it.addr, {it.rq, " write address"}, {16'h0, mem_last_addr}, {16'h0, it.addr});
            chk(mem_last_data == it.data, {it.rq, " write data"}, mem_last_data, it.data);
            chk(mem_first_cyc == it.cyc + 1, "R6 write launched next cycle", mem_first_cyc, it.cyc + 1);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < LN; i++) mdl_v[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1 no memory request after reset", {31'h0, mem_req_valid}, 32'h0);

    // cold load then hit
    do_req(1'b0, 16'h0012, '0, "R1 cold miss");
    do_req(1'b0, 16'h0012, '0, "R2 hit");
    // store hit then load
    do_req(1'b1, 16'h0012, 32'hCAFE_0001, "R4 store hit");
    do_req(1'b0, 16'h0012, '0, "R4 load after store hit");
    // store miss on empty line
    do_req(1'b1, 16'h0153, 32'h1234_5678, "R5 store miss");
    do_req(1'b0, 16'h0153, '0, "R5 load after store miss");
    // store miss on occupied index
    do_req(1'b0, 16'h0005, '0, "R3 fill");
    do_req(1'b1, 16'h1005, 32'hBEEF_0005, "R5 store miss conflict");
    do_req(1'b0, 16'h0005, '0, "R5 resident line kept");
    // eviction by load miss with the same index
    do_req(1'b0, 16'h1005, '0, "R9 conflicting load");
    do_req(1'b0, 16'h0005, '0, "R9 evicted line misses");
    do_req(1'b0, 16'h1005, '0, "R9 new line hits");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {10'h0, 2'(lfsr[5:4] % 3), 2'b00, lfsr[1:0]};
      do_req(lfsr[8], a, {lfsr, lfsr ^ 16'h5A5A}, lfsr[8] ? "R6 random store" : "R3 random load");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule